// File: doc/BRIEF.md
# Programmable Memory Bank Chip-Select Controller

This block is the address-decode front end of an external memory controller. A bus master offers a transfer (address, address-type code, transfer size, read/write) on a valid/ready request channel. The controller compares the address against eight programmable bank descriptors. It then drives the chip select of the winning bank, along with byte-lane enables shaped by that bank's port width and an output enable for reads. It holds the chip select for a per-bank number of wait states and closes the transfer with a one-cycle acknowledge. An address that no bank claims ends with a one-cycle transfer error and no chip select.

Each descriptor holds a valid flag, a base tag, a power-of-two block size code, a wait-state count, a port width and an address-type value/mask pair. A whole descriptor is written in one cycle through a plain configuration port. One bank comes out of reset already enabled and covers the bottom of the address space, so instruction fetch can start before any descriptor is written.

Back-pressure rules: `req_ready` is high only while no transfer is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The master must hold its fields stable until then. After a transfer ends, `req_ready` returns the following cycle.

Top module: `memcs_ctrl`

## Requirements
- R1: A bank hits when its valid flag is set and the address bits above its block size equal its base tag. The field `cfg_base` carries address bits 31:15. `bank_cs` is active high with bit i for bank i, and it is never more than one-hot.
- R2: Block size code s (0..13) gives a block of 32 KB << s, so address bits [31:15+s] are compared. Codes 14 and 15 are stored as 13 (256 MB).
- R3: When several banks hit, the lowest-numbered one is selected.
- R4: With W wait states (0..30; a written 31 is stored as 30), chip select is active for W+1 cycles, starting the cycle after the request is accepted. `xfer_ack` is high for exactly the last of those cycles.
- R5: A bank hits only if `((req_atype ^ at_val) & at_mask) == 0`. A mask bit of 1 means that address-type bit is compared.
- R6: Port code 0/1/2 means an 8/16/32-bit port, and code 3 is treated as 32-bit. Size code 0/1/2 means byte/half/word, and code 3 is treated as word. The effective size is the smaller of the size and the port. `byte_en` bit k enables lane k. The enabled lanes are a run of effective-size bytes, starting at (addr[1:0] modulo port bytes) aligned down to the effective size.
- R7: `byte_en` is nonzero only while a chip select is active. `out_en` is high exactly during the chip-select cycles of a read.
- R8: If no bank hits, `xfer_err` is high for one cycle, the cycle after acceptance, with no chip select and no acknowledge.
- R9: After reset, bank 0 is valid with base 0, size code 13, 30 wait states, a 32-bit port and an address-type mask of 0. All other banks are invalid.
- R10: `req_ready` is low from acceptance to the end of the transfer. Wait count, lanes and selection are captured at acceptance, so a descriptor write during a transfer affects only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | 32 | Byte address |
| req_atype | input | 4 | Address-type code |
| req_size | input | 2 | Transfer size code |
| req_read | input | 1 | 1 = read, 0 = write |
| cfg_we | input | 1 | Write one descriptor |
| cfg_bank | input | 3 | Descriptor index |
| cfg_valid | input | 1 | Bank enable |
| cfg_base | input | 17 | Base tag (address bits 31:15) |
| cfg_size | input | 4 | Block size code |
| cfg_wait | input | 5 | Wait-state count |
| cfg_port | input | 2 | Port width code |
| cfg_at_val | input | 4 | Address-type compare value |
| cfg_at_mask | input | 4 | Address-type compare mask |
| bank_cs | output | 8 | Per-bank chip selects |
| byte_en | output | 4 | Byte-lane enables |
| out_en | output | 1 | Output enable (reads) |
| xfer_ack | output | 1 | Transfer acknowledge |
| xfer_err | output | 1 | Transfer error (no bank hit) |

## Verification
The hardest situation to reach from the ports is a descriptor rewrite that lands while a transfer to that same bank is still holding its chip select. The stimulus gets there through a driver task that returns as soon as the request is accepted. The sequence then writes a new wait count to that bank during the in-flight transfer, and the scoreboard expects the old count for that transfer and the new one for the next. Overlapping banks with different sizes and address-type masks are layered so that priority, block-size edges and qualifier misses each decide at least one outcome.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
  localparam int ADDR_W   = 32;
  localparam int BLK_LSB  = 15;
  localparam int TAG_W    = ADDR_W - BLK_LSB;
  localparam int SZ_W     = 4;
  localparam int MAX_SZ   = 13;
  localparam int WAIT_W   = 5;
  localparam int MAX_WAIT = 30;
  localparam int AT_W     = 4;
  localparam int LANES    = 4;

  typedef enum logic [1:0] {
    PORT8   = 2'd0,
    PORT16  = 2'd1,
    PORT32  = 2'd2,
    PORT32X = 2'd3
  } port_e;

  typedef struct packed {
    logic              valid;
    logic [TAG_W-1:0]  base;
    logic [SZ_W-1:0]   size;
    logic [WAIT_W-1:0] waits;
    port_e             port;
    logic [AT_W-1:0]   at_val;
    logic [AT_W-1:0]   at_mask;
  } bank_desc_t;
endpackage

// File: rtl/memcs_bank_regs.sv
module memcs_bank_regs
  import memcs_pkg::*;
#(
  parameter int NBANK     = 8,
  parameter int BOOT_BANK = 0,
  parameter int BOOT_PORT = 2,
  localparam int IDX_W    = $clog2(NBANK)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_bank,
  input  logic                         cfg_valid,
  input  logic [TAG_W-1:0]             cfg_base,
  input  logic [SZ_W-1:0]              cfg_size,
  input  logic [WAIT_W-1:0]            cfg_wait,
  input  logic [1:0]                   cfg_port,
  input  logic [AT_W-1:0]              cfg_at_val,
  input  logic [AT_W-1:0]              cfg_at_mask,
  output bank_desc_t [NBANK-1:0]       desc
);
  bank_desc_t boot_d;
  bank_desc_t wr_d;

  // descriptor the boot bank wakes up with
  always_comb begin
    boot_d         = '0;
    boot_d.valid   = 1'b1;
    boot_d.size    = SZ_W'(MAX_SZ);
    boot_d.waits   = WAIT_W'(MAX_WAIT);
    boot_d.port    = port_e'(BOOT_PORT);
  end

  // clamp out-of-range codes once, on the way in
  always_comb begin
    wr_d         = '0;
    wr_d.valid   = cfg_valid;
    wr_d.base    = cfg_base;
    wr_d.size    = (cfg_size > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : cfg_size;
    wr_d.waits   = (cfg_wait > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : cfg_wait;
    wr_d.port    = port_e'(cfg_port);
    wr_d.at_val  = cfg_at_val;
    wr_d.at_mask = cfg_at_mask;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_desc_t q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= (b == BOOT_BANK) ? boot_d : '0;
      end else if (cfg_we && (cfg_bank == IDX_W'(b))) begin
        q <= wr_d;
      end
    end
    assign desc[b] = q;
  end
endmodule

// File: rtl/memcs_match.sv
module memcs_match
  import memcs_pkg::*;
#(
  parameter int NBANK = 8
) (
  input  bank_desc_t [NBANK-1:0] desc,
  input  logic [TAG_W-1:0]       addr_tag,
  input  logic [AT_W-1:0]        atype,
  output logic                   hit,
  output logic [NBANK-1:0]       sel,
  output logic [WAIT_W-1:0]      sel_waits,
  output port_e                  sel_port
);
  logic [NBANK-1:0] raw;

  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    logic [TAG_W-1:0] keep;
    logic             tag_ok;
    logic             at_ok;
    assign keep   = {TAG_W{1'b1}} << desc[b].size;
    assign tag_ok = ((addr_tag ^ desc[b].base) & keep) == '0;
    assign at_ok  = ((atype ^ desc[b].at_val) & desc[b].at_mask) == '0;
    assign raw[b] = desc[b].valid && tag_ok && at_ok;
  end

  // isolate the lowest set bit: lowest bank number wins
  assign sel = raw & (~raw + NBANK'(1));
  assign hit = |raw;

  always_comb begin
    logic [1:0] p;
    sel_waits = '0;
    p         = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (sel[i]) begin
        sel_waits = sel_waits | desc[i].waits;
        p         = p | desc[i].port;
      end
    end
    sel_port = port_e'(p);
  end
endmodule

// File: rtl/memcs_lanes.sv
module memcs_lanes
  import memcs_pkg::*;
(
  input  port_e            port,
  input  logic [1:0]       size,
  input  logic [1:0]       addr_lo,
  output logic [LANES-1:0] be
);
  logic [1:0] pw;
  logic [1:0] es;
  logic [1:0] port_keep;
  logic [1:0] align_keep;
  logic [1:0] off;
  logic [LANES-1:0] span;

  always_comb begin
    pw = (port == PORT32X) ? 2'd2 : 2'(port);
    es = (size == 2'd3) ? 2'd2 : size;
    if (es > pw) es = pw;

    unique case (pw)
      2'd0:    port_keep = 2'b00;
      2'd1:    port_keep = 2'b01;
      default: port_keep = 2'b11;
    endcase

    unique case (es)
      2'd0:    begin align_keep = 2'b11; span = 4'b0001; end
      2'd1:    begin align_keep = 2'b10; span = 4'b0011; end
      default: begin align_keep = 2'b00; span = 4'b1111; end
    endcase

    off = addr_lo & port_keep & align_keep;
    be  = span << off;
  end
endmodule

// File: rtl/memcs_xfer.sv
module memcs_xfer
  import memcs_pkg::*;
#(
  parameter int NBANK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic              hit,
  input  logic [NBANK-1:0]  sel,
  input  logic [WAIT_W-1:0] waits,
  input  logic [LANES-1:0]  lanes,
  output logic              req_ready,
  output logic [NBANK-1:0]  cs,
  output logic [LANES-1:0]  be,
  output logic              oe,
  output logic              ack,
  output logic              err
);
  logic              busy_q;
  logic              hit_q;
  logic              rd_q;
  logic [NBANK-1:0]  sel_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [LANES-1:0]  be_q;
  logic              active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hit_q  <= 1'b0;
      rd_q   <= 1'b0;
      sel_q  <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else if (!busy_q) begin
      if (req_valid) begin
        busy_q <= 1'b1;
        hit_q  <= hit;
        rd_q   <= req_read;
        sel_q  <= sel;
        cnt_q  <= waits;
        be_q   <= lanes;
      end
    end else if (!hit_q || (cnt_q == '0)) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - WAIT_W'(1);
    end
  end

  assign active    = busy_q && hit_q;
  assign req_ready = !busy_q;
  assign cs        = active ? sel_q : '0;
  assign be        = active ? be_q : '0;
  assign oe        = active && rd_q;
  assign ack       = active && (cnt_q == '0);
  assign err       = busy_q && !hit_q;
endmodule

// File: rtl/memcs_ctrl.sv
module memcs_ctrl
  import memcs_pkg::*;
#(
  parameter int NBANK     = 8,
  parameter int BOOT_BANK = 0,
  parameter int BOOT_PORT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [31:0]                req_addr,
  input  logic [3:0]                 req_atype,
  input  logic [1:0]                 req_size,
  input  logic                       req_read,
  input  logic                       cfg_we,
  input  logic [$clog2(NBANK)-1:0]   cfg_bank,
  input  logic                       cfg_valid,
  input  logic [16:0]                cfg_base,
  input  logic [3:0]                 cfg_size,
  input  logic [4:0]                 cfg_wait,
  input  logic [1:0]                 cfg_port,
  input  logic [3:0]                 cfg_at_val,
  input  logic [3:0]                 cfg_at_mask,
  output logic [NBANK-1:0]           bank_cs,
  output logic [3:0]                 byte_en,
  output logic                       out_en,
  output logic                       xfer_ack,
  output logic                       xfer_err
);
  bank_desc_t [NBANK-1:0] desc;
  logic                   hit;
  logic [NBANK-1:0]       sel;
  logic [WAIT_W-1:0]      sel_waits;
  port_e                  sel_port;
  logic [LANES-1:0]       lanes;
  logic                   unused_addr_mid;

  assign unused_addr_mid = ^req_addr[BLK_LSB-1:2];

  memcs_bank_regs #(
    .NBANK     (NBANK),
    .BOOT_BANK (BOOT_BANK),
    .BOOT_PORT (BOOT_PORT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_bank    (cfg_bank),
    .cfg_valid   (cfg_valid),
    .cfg_base    (cfg_base),
    .cfg_size    (cfg_size),
    .cfg_wait    (cfg_wait),
    .cfg_port    (cfg_port),
    .cfg_at_val  (cfg_at_val),
    .cfg_at_mask (cfg_at_mask),
    .desc        (desc)
  );

  memcs_match #(.NBANK(NBANK)) u_match (
    .desc      (desc),
    .addr_tag  (req_addr[ADDR_W-1:BLK_LSB]),
    .atype     (req_atype),
    .hit       (hit),
    .sel       (sel),
    .sel_waits (sel_waits),
    .sel_port  (sel_port)
  );

  memcs_lanes u_lanes (
    .port    (sel_port),
    .size    (req_size),
    .addr_lo (req_addr[1:0]),
    .be      (lanes)
  );

  memcs_xfer #(.NBANK(NBANK)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_read  (req_read),
    .hit       (hit),
    .sel       (sel),
    .waits     (sel_waits),
    .lanes     (lanes),
    .req_ready (req_ready),
    .cs        (bank_cs),
    .be        (byte_en),
    .oe        (out_en),
    .ack       (xfer_ack),
    .err       (xfer_err)
  );
endmodule

// File: rtl/memcs_ctrl_chk.sv
module memcs_ctrl_chk #(
  parameter int NBANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [NBANK-1:0] bank_cs,
  input logic [3:0]       byte_en,
  input logic             out_en,
  input logic             xfer_ack,
  input logic             xfer_err
);
  logic [5:0] run_q;

  // consecutive cycles a chip select has already been held
  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (|bank_cs) run_q <= run_q + 6'd1;
    else               run_q <= '0;
  end

  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs));

  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);

  a_r4_ack_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (|bank_cs));

  a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (run_q <= 6'd30));

  a_r4_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_cs) && !xfer_ack) |=> ($stable(bank_cs) && $stable(byte_en)));

  a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (|bank_cs));

  a_r7_be_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (|byte_en) |-> (|bank_cs));

  a_r8_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> ((bank_cs == '0) && !xfer_ack));

  a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !xfer_err);

  a_r8_err_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> $past(req_valid && req_ready));

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_cs) || xfer_err) |-> !req_ready);
endmodule

bind memcs_ctrl memcs_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bank_cs   (bank_cs),
  .byte_en   (byte_en),
  .out_en    (out_en),
  .xfer_ack  (xfer_ack),
  .xfer_err  (xfer_err)
);

// File: tb/tb_memcs_ctrl.sv
module tb_memcs_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_atype = '0;
  logic [1:0]  req_size = '0;
  logic        req_read = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bank = '0;
  logic        cfg_valid = 1'b0;
  logic [16:0] cfg_base = '0;
  logic [3:0]  cfg_size = '0;
  logic [4:0]  cfg_wait = '0;
  logic [1:0]  cfg_port = '0;
  logic [3:0]  cfg_at_val = '0;
  logic [3:0]  cfg_at_mask = '0;
  logic [7:0]  bank_cs;
  logic [3:0]  byte_en;
  logic        out_en;
  logic        xfer_ack;
  logic        xfer_err;

  always #10 clk = ~clk;  // 50 MHz

  memcs_ctrl dut (.*);

  int nchk = 0;
  int nfail = 0;

  // bench mirror of the descriptors
  logic        m_valid [8];
  logic [16:0] m_base  [8];
  int          m_size  [8];
  int          m_wait  [8];
  int          m_port  [8];
  logic [3:0]  m_atv   [8];
  logic [3:0]  m_atm   [8];

  // scoreboard queues
  logic        q_err [$];
  logic [7:0]  q_cs  [$];
  logic [3:0]  q_be  [$];
  logic        q_oe  [$];
  int          q_w   [$];
  string       q_tag [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes_model(int port, int size, logic [31:0] a);
    int pb, tb, off;
    logic [3:0] r;
    pb = (port == 0) ? 1 : (port == 1) ? 2 : 4;
    tb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    if (tb > pb) tb = pb;
    off = int'(a[1:0]) % pb;
    off = off - (off % tb);
    r = '0;
    for (int k = 0; k < tb; k++) r[off + k] = 1'b1;
    return r;
  endfunction

  task automatic cfg(int b, logic v, logic [31:0] base_addr, int sz, int w,
                     int port, logic [3:0] atv, logic [3:0] atm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 3'(b); cfg_valid = v;
    cfg_base = base_addr[31:15]; cfg_size = 4'(sz); cfg_wait = 5'(w);
    cfg_port = 2'(port); cfg_at_val = atv; cfg_at_mask = atm;
    @(negedge clk);
    cfg_we = 1'b0;
    m_valid[b] = v; m_base[b] = base_addr[31:15];
    m_size[b] = (sz > 13) ? 13 : sz;
    m_wait[b] = (w > 30) ? 30 : w;
    m_port[b] = port; m_atv[b] = atv; m_atm[b] = atm;
  endtask

  task automatic issue(logic [31:0] a, logic [3:0] at, int sz, logic rd, string tag);
    int win;
    win = -1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      if (m_valid[b] && ((a >> (15 + m_size[b])) == ({15'b0, m_base[b]} >> m_size[b]))
          && (((at ^ m_atv[b]) & m_atm[b]) == 4'h0))
        win = b;
    end
    if (win < 0) begin
      q_err.push_back(1'b1); q_cs.push_back('0); q_be.push_back('0);
      q_oe.push_back(1'b0); q_w.push_back(0);
    end else begin
      q_err.push_back(1'b0); q_cs.push_back(8'(1) << win);
      q_be.push_back(lanes_model(m_port[win], sz, a));
      q_oe.push_back(rd); q_w.push_back(m_wait[win]);
    end
    q_tag.push_back(tag);
    req_valid = 1'b1; req_addr = a; req_atype = at; req_size = 2'(sz); req_read = rd;
    @(negedge clk);
    req_valid = 1'b0;
    check({"R10 ready low after accept ", tag}, 32'(req_ready), 0);
  endtask

  task automatic drain();
    @(negedge clk);
    while (q_tag.size() != 0 || !req_ready) @(negedge clk);
  endtask

  // monitor: pops one expected item per finished transfer
  int run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (|bank_cs) run++;
      if (xfer_ack || xfer_err) begin
        if (q_tag.size() == 0) begin
          check("R8 unexpected completion", 1, 0);
        end else begin
          logic e; logic [7:0] c; logic [3:0] b; logic o; int w; string t;
          e = q_err.pop_front(); c = q_cs.pop_front(); b = q_be.pop_front();
          o = q_oe.pop_front(); w = q_w.pop_front(); t = q_tag.pop_front();
          check({t, " err"}, 32'(xfer_err), 32'(e));
          check({t, " ack"}, 32'(xfer_ack), 32'(!e));
          check({t, " cs"}, 32'(bank_cs), 32'(c));
          check({t, " be"}, 32'(byte_en), 32'(b));
          check({t, " oe"}, 32'(out_en), 32'(o));
          check({t, " R4 cs cycles"}, 32'(run), e ? 0 : 32'(w + 1));
        end
        run = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R4 watchdog: transfer never completed");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) begin
      m_valid[b] = 1'b0; m_base[b] = '0; m_size[b] = 0; m_wait[b] = 0;
      m_port[b] = 0; m_atv[b] = '0; m_atm[b] = '0;
    end
    // R9 boot descriptor
    m_valid[0] = 1'b1; m_size[0] = 13; m_wait[0] = 30; m_port[0] = 2;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 cs idle", 32'(bank_cs), 0);
    check("R9 ack idle", 32'(xfer_ack), 0);
    check("R9 err idle", 32'(xfer_err), 0);
    check("R9 ready", 32'(req_ready), 1);

    issue(32'h0000_0100, 4'h0, 2, 1'b1, "R9 boot read");
    issue(32'h0FFF_FFFC, 4'h3, 2, 1'b0, "R2 boot top of 256MB");
    issue(32'h1000_0000, 4'h0, 2, 1'b1, "R8 past boot block");
    drain();

    cfg(2, 1'b1, 32'h4000_0000, 0, 0, 0, 4'h0, 4'h0);
    issue(32'h4000_7FFF, 4'h0, 0, 1'b1, "R2 32KB edge in");
    issue(32'h4000_8000, 4'h0, 0, 1'b1, "R2 32KB edge out");
    issue(32'h4000_0003, 4'h0, 2, 1'b1, "R6 word to 8-bit port");
    drain();

    cfg(1, 1'b1, 32'h4000_0000, 1, 3, 1, 4'h0, 4'h0);
    issue(32'h4000_0002, 4'h0, 1, 1'b0, "R3 lower bank wins");
    issue(32'h4000_8001, 4'h0, 0, 1'b1, "R6 byte lane 1 on 16-bit");
    issue(32'h4000_8003, 4'h0, 2, 1'b1, "R6 word on 16-bit");
    drain();

    cfg(3, 1'b1, 32'h8000_0000, 15, 31, 3, 4'h5, 4'hF);
    issue(32'h8FFF_FFFE, 4'h5, 1, 1'b1, "R5 atype match, R2 clamp, R4 max");
    issue(32'h8000_0000, 4'h4, 1, 1'b1, "R5 atype mismatch");
    issue(32'h9000_0000, 4'h5, 2, 1'b1, "R2 clamped block end");
    drain();
    cfg(3, 1'b1, 32'h8000_0000, 13, 2, 2, 4'h4, 4'hC);
    issue(32'h8000_0003, 4'h7, 0, 1'b1, "R5 masked bits ignored, R6 lane 3");
    issue(32'h8000_0003, 4'hB, 0, 1'b1, "R5 compared bit differs");
    issue(32'h8000_0003, 4'h4, 1, 1'b0, "R6 half aligned down");
    issue(32'h8000_0002, 4'h4, 2, 1'b0, "R6 word aligned down");
    drain();

    cfg(0, 1'b0, 32'h0, 13, 30, 2, 4'h0, 4'h0);
    issue(32'h0000_0000, 4'h0, 2, 1'b1, "R1 invalid bank ignored");
    drain();

    // R10: rewrite bank 1 while its transfer holds chip select
    issue(32'h4000_0000, 4'h0, 1, 1'b1, "R10 old wait kept");
    cfg(1, 1'b1, 32'h4000_0000, 1, 0, 1, 4'h0, 4'h0);
    issue(32'h4000_0000, 4'h0, 1, 1'b1, "R10 new wait used");
    drain();

    repeat (4) @(negedge clk);
    check("R7 idle after run", 32'({byte_en, out_en, xfer_ack}), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule